// File: doc/BRIEF.md
# Linked Descriptor Channel Sequencer

This block is the control half of one DMA channel whose work is described by a linked list of descriptors kept in memory. Software places a pointer to the first descriptor in a register and writes a fetch request into the control register. The sequencer then reads the four descriptor words over a word-wide memory read port and keeps the byte count, source and destination in working registers. It presents these as a job to an external data mover. When the mover signals the end of the job, the sequencer sets a sticky completion flag, which can raise an interrupt, and goes on to the descriptor that the embedded link points to.

A link that points back to an earlier descriptor forms a ring, and the channel then runs until software aborts it. Pause and resume act on the enable bit, and the job and position are kept while the channel is paused. Abort returns the channel to rest at once.

The sequencer has three states. `SEQ_IDLE` is the rest state. In `SEQ_FETCH` it reads descriptor words 0 to 3. In `SEQ_MOVE` the job is handed to the mover. It has these transitions:
- *launch*: `SEQ_IDLE` to `SEQ_FETCH` on a fetch request.
- *loaded*: `SEQ_FETCH` to `SEQ_MOVE` when the fourth word is accepted.
- *follow*: `SEQ_MOVE` to `SEQ_FETCH` when a job finishes and the link is non-zero.
- *retire*: `SEQ_MOVE` to `SEQ_IDLE` when a job finishes and the link is zero.
- *kill*: `SEQ_FETCH` or `SEQ_MOVE` to `SEQ_IDLE` on abort.

Top module: `desc_chain_ctl`

## Requirements
- R1: After reset, every register reads zero (control at 0x40, status at 0xA0, current descriptor at 0x70, byte count at 0x00), and both `xfer_run` and `irq` are low.
- R2: A control write with bit 13 set, made while the channel is idle, starts a fetch. The fetch uses the next-pointer register (0x30) with its low four bits forced to zero, and that aligned address appears in the current-descriptor register. The four words are read at offsets +0, +4, +8 and +12 as byte count, source, destination and next link. The count, source and destination can be read back at 0x00, 0x10 and 0x20.
- R3: `xfer_run` is high only while a loaded job exists and control bit 12 (enable) is set, and `xfer_src`, `xfer_dst` and `xfer_len` then carry the loaded values. A fetch request made while the channel is disabled only loads the descriptor, and the job starts once bit 12 is set.
- R4: A fetched byte count above `MAX_XFER` (65536 by default) is loaded as `MAX_XFER`.
- R5: When `xfer_done` is high in a cycle where `xfer_run` is high, status bit 0 is set and the stored link is followed. A link whose bits above the low four are all zero ends the chain, and the channel returns to idle.
- R6: A ring, in which the last link points to the first descriptor, is followed without end, and the descriptors are visited in ring order.
- R7: Clearing bit 12 during a job drops `xfer_run` and keeps the channel active, the current descriptor and the job. Setting bit 12 again resumes the same job with no new fetch.
- R8: A control write with bit 20 set sends the channel to idle at once and clears the enable bit. This holds even when bit 13 is set in the same write.
- R9: Control bit 14 reads one exactly while the channel is not idle. Bits 13 and 20 always read zero.
- R10: Writing status with bit 0 at zero clears the flag, and writing one leaves it unchanged. `irq` is high when status bit 0 and mask bit 0 (register 0x80) are both set.
- R11: A fetch request made while the channel is not idle is ignored, and the current descriptor and the job stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Byte address of the descriptor word |
| mem_ack | input | 1 | Read data valid; the word is taken in this cycle |
| mem_rdata | input | 32 | Descriptor word |
| xfer_run | output | 1 | Job active and enabled; the mover may work |
| xfer_src | output | AW | Job source address |
| xfer_dst | output | AW | Job destination address |
| xfer_len | output | LEN_W | Job byte count |
| xfer_done | input | 1 | Mover finished the job |
| irq | output | 1 | Masked completion interrupt |

## Verification
The main function is exercised with four chain shapes. A two-entry linear chain shows that links are followed and that a zero link ends the chain. A single descriptor with an unaligned pointer and an oversize count separates alignment and clamping from plain loading. A fetch made while the channel is disabled shows that loading is separate from running. A two-entry ring run for six jobs shows that the chain loops in order rather than stopping. A scoreboard holds the expected job list and compares each job when the mover first sees it, so a repeated, skipped or reordered job shows up as a mismatch. Pause with a fetch request during the pause, and abort combined with fetch, test the priority between the control actions.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_MOVE  = 2'd2
    } seq_state_e;

    localparam logic [7:0] OFF_COUNT = 8'h00;
    localparam logic [7:0] OFF_SRC   = 8'h10;
    localparam logic [7:0] OFF_DST   = 8'h20;
    localparam logic [7:0] OFF_NEXT  = 8'h30;
    localparam logic [7:0] OFF_CTRL  = 8'h40;
    localparam logic [7:0] OFF_CUR   = 8'h70;
    localparam logic [7:0] OFF_MASK  = 8'h80;
    localparam logic [7:0] OFF_STAT  = 8'hA0;

    localparam int BIT_EN     = 12;
    localparam int BIT_FETCH  = 13;
    localparam int BIT_ACTIVE = 14;
    localparam int BIT_ABORT  = 20;

endpackage

// File: rtl/desc_chain_regs.sv
module desc_chain_regs
    import desc_chain_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             active,
    input  logic             done_evt,
    input  logic [LEN_W-1:0] cnt_q,
    input  logic [AW-1:0]    src_q,
    input  logic [AW-1:0]    dst_q,
    input  logic [AW-1:0]    next_q,
    input  logic [AW-1:0]    cur_q,
    output logic             en_q,
    output logic             mask_q,
    output logic             sts_q,
    output logic             fetch_pulse,
    output logic             abort_pulse,
    output logic             irq
);

    logic ctrl_wr;

    assign ctrl_wr     = reg_wr && (reg_addr == OFF_CTRL);
    assign abort_pulse = ctrl_wr && reg_wdata[BIT_ABORT];
    assign fetch_pulse = ctrl_wr && reg_wdata[BIT_FETCH] && !reg_wdata[BIT_ABORT];
    assign irq         = sts_q && mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
            sts_q  <= 1'b0;
        end else begin
            if (abort_pulse)
                en_q <= 1'b0;
            else if (ctrl_wr)
                en_q <= reg_wdata[BIT_EN];
            if (reg_wr && reg_addr == OFF_MASK)
                mask_q <= reg_wdata[0];
            if (done_evt)
                sts_q <= 1'b1;
            else if (reg_wr && reg_addr == OFF_STAT)
                sts_q <= sts_q & reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_COUNT: reg_rdata = 32'(cnt_q);
            OFF_SRC:   reg_rdata = 32'(src_q);
            OFF_DST:   reg_rdata = 32'(dst_q);
            OFF_NEXT:  reg_rdata = 32'(next_q);
            OFF_CUR:   reg_rdata = 32'(cur_q);
            OFF_MASK:  reg_rdata[0] = mask_q;
            OFF_STAT:  reg_rdata[0] = sts_q;
            OFF_CTRL: begin
                reg_rdata[BIT_EN]     = en_q;
                reg_rdata[BIT_ACTIVE] = active;
            end
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
    import desc_chain_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_XFER = 65536,
    parameter int LEN_W    = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_pulse,
    input  logic             abort_pulse,
    input  logic             en,
    input  logic             sw_wr,
    input  logic [7:0]       sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             xfer_done,
    output logic             xfer_run,
    output logic             active,
    output logic             done_evt,
    output logic [LEN_W-1:0] cnt_q,
    output logic [AW-1:0]    src_q,
    output logic [AW-1:0]    dst_q,
    output logic [AW-1:0]    next_q,
    output logic [AW-1:0]    cur_q
);

    localparam int         WORDS    = 4;
    localparam int         IDX_W    = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [AW-1:0]    next_aligned;
    logic             link_end;
    logic             word_take;

    assign next_aligned = {next_q[AW-1:4], 4'b0000};
    assign link_end     = (next_q[AW-1:4] == '0);
    assign word_take    = (state_q == SEQ_FETCH) && mem_ack && !abort_pulse;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (fetch_pulse) state_d = SEQ_FETCH;
            SEQ_FETCH: begin
                if (abort_pulse)                      state_d = SEQ_IDLE;
                else if (mem_ack && idx_q == LAST_IDX) state_d = SEQ_MOVE;
            end
            SEQ_MOVE: begin
                if (abort_pulse)          state_d = SEQ_IDLE;
                else if (en && xfer_done) state_d = link_end ? SEQ_IDLE : SEQ_FETCH;
            end
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mem_req  = (state_q == SEQ_FETCH);
        mem_addr = cur_q + AW'({idx_q, 2'b00});
        xfer_run = (state_q == SEQ_MOVE) && en;
        active   = (state_q != SEQ_IDLE);
        done_evt = xfer_run && xfer_done && !abort_pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            cnt_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            next_q <= '0;
            cur_q  <= '0;
        end else begin
            if (sw_wr) begin
                unique case (sw_addr)
                    OFF_COUNT: cnt_q  <= sw_wdata[LEN_W-1:0];
                    OFF_SRC:   src_q  <= sw_wdata[AW-1:0];
                    OFF_DST:   dst_q  <= sw_wdata[AW-1:0];
                    OFF_NEXT:  next_q <= sw_wdata[AW-1:0];
                    default: ;
                endcase
            end
            if (abort_pulse)
                idx_q <= '0;
            else if (word_take)
                idx_q <= idx_q + 1'b1;
            if (word_take) begin
                unique case (idx_q)
                    2'd0: cnt_q <= (mem_rdata > 32'(MAX_XFER)) ? LEN_W'(MAX_XFER)
                                                                : mem_rdata[LEN_W-1:0];
                    2'd1: src_q  <= mem_rdata[AW-1:0];
                    2'd2: dst_q  <= mem_rdata[AW-1:0];
                    default: next_q <= mem_rdata[AW-1:0];
                endcase
            end
            if ((state_q == SEQ_IDLE && fetch_pulse) || (done_evt && !link_end))
                cur_q <= next_aligned;
        end
    end

endmodule

// File: rtl/desc_chain_ctl.sv
module desc_chain_ctl
    import desc_chain_pkg::*;
#(
    parameter  int AW       = 32,
    parameter  int MAX_XFER = 65536,
    localparam int LEN_W    = $clog2(MAX_XFER + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             xfer_run,
    output logic [AW-1:0]    xfer_src,
    output logic [AW-1:0]    xfer_dst,
    output logic [LEN_W-1:0] xfer_len,
    input  logic             xfer_done,
    output logic             irq
);

    logic             en_q, mask_q, sts_q;
    logic             fetch_pulse, abort_pulse;
    logic             active, done_evt;
    logic [LEN_W-1:0] cnt_q;
    logic [AW-1:0]    src_q, dst_q, next_q, cur_q;

    desc_chain_regs #(.AW(AW), .LEN_W(LEN_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .active      (active),
        .done_evt    (done_evt),
        .cnt_q       (cnt_q),
        .src_q       (src_q),
        .dst_q       (dst_q),
        .next_q      (next_q),
        .cur_q       (cur_q),
        .en_q        (en_q),
        .mask_q      (mask_q),
        .sts_q       (sts_q),
        .fetch_pulse (fetch_pulse),
        .abort_pulse (abort_pulse),
        .irq         (irq)
    );

    desc_chain_seq #(.AW(AW), .MAX_XFER(MAX_XFER), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_pulse (fetch_pulse),
        .abort_pulse (abort_pulse),
        .en          (en_q),
        .sw_wr       (reg_wr),
        .sw_addr     (reg_addr),
        .sw_wdata    (reg_wdata),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .xfer_done   (xfer_done),
        .xfer_run    (xfer_run),
        .active      (active),
        .done_evt    (done_evt),
        .cnt_q       (cnt_q),
        .src_q       (src_q),
        .dst_q       (dst_q),
        .next_q      (next_q),
        .cur_q       (cur_q)
    );

    assign xfer_src = src_q;
    assign xfer_dst = dst_q;
    assign xfer_len = cnt_q;

endmodule

// File: rtl/desc_chain_chk.sv
module desc_chain_chk
    import desc_chain_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_XFER = 65536,
    parameter int LEN_W    = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             mem_req,
    input logic [AW-1:0]    mem_addr,
    input logic             xfer_run,
    input logic             xfer_done,
    input logic [LEN_W-1:0] xfer_len,
    input logic             en_q,
    input logic             sts_q,
    input logic             active,
    input logic             abort_pulse,
    input logic [AW-1:0]    cur_q
);

    assert_run_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_run |-> en_q);

    assert_len_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_run |-> (xfer_len <= LEN_W'(MAX_XFER)));

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00 && cur_q[3:0] == 4'h0));

    assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_run && xfer_done && !abort_pulse) |=> sts_q);

    assert_abort_to_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> (!active && !en_q && !xfer_run));

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_STAT && !reg_wdata[0] && !(xfer_run && xfer_done))
            |=> !sts_q);

endmodule

bind desc_chain_ctl desc_chain_chk #(.AW(AW), .MAX_XFER(MAX_XFER), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .xfer_run    (xfer_run),
    .xfer_done   (xfer_done),
    .xfer_len    (xfer_len),
    .en_q        (en_q),
    .sts_q       (sts_q),
    .active      (active),
    .abort_pulse (abort_pulse),
    .cur_q       (cur_q)
);

// File: tb/desc_chain_ctl_tb_top.sv
module desc_chain_ctl_tb_top;
    import desc_chain_pkg::*;

    localparam int AW = 32;
    localparam int LW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          xfer_run, xfer_done = 1'b0, irq;
    logic [AW-1:0] xfer_src, xfer_dst;
    logic [LW-1:0] xfer_len;
    logic [31:0]   mem [64];

    always #4 clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:2]];

    desc_chain_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .xfer_run(xfer_run), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .irq(irq)
    );

    typedef struct {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] len;
    } job_t;

    job_t exp_q[$];
    int   n_chk = 0, n_bad = 0;
    int   start_cnt = 0, done_cnt = 0, done_limit = 0, run_cnt = 0;
    bit   seen = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input int at, input logic [31:0] len, src, dst, nxt);
        mem[at/4]     = len;
        mem[at/4 + 1] = src;
        mem[at/4 + 2] = dst;
        mem[at/4 + 3] = nxt;
    endtask

    task automatic expect_job(input logic [31:0] src, dst, len);
        job_t j;
        j.src = src; j.dst = dst; j.len = len;
        exp_q.push_back(j);
    endtask

    // monitor and mover model: compares each new job with the scoreboard
    always @(negedge clk) begin
        job_t e;
        xfer_done = 1'b0;
        if (rst_n && xfer_run) begin
            if (!seen) begin
                seen = 1'b1;
                start_cnt++;
                run_cnt = 0;
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R3 unexpected job actual=%h expected=none", xfer_src);
                end else begin
                    e = exp_q.pop_front();
                    check("R3 job src", xfer_src, e.src);
                    check("R3 job dst", xfer_dst, e.dst);
                    check("R4 job len", 32'(xfer_len), e.len);
                end
            end
            run_cnt++;
            if (run_cnt >= 3 && done_cnt < done_limit) begin
                xfer_done = 1'b1;
                done_cnt++;
                seen = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        put_desc(32'h10, 32'h40, 32'h1000, 32'h2000, 32'h20);
        put_desc(32'h20, 32'h80, 32'h3000, 32'h4000, 32'h0);
        put_desc(32'h30, 32'h0002_0000, 32'h5000, 32'h6000, 32'h0);
        put_desc(32'h40, 32'h20, 32'h7000, 32'h8000, 32'h0);
        put_desc(32'h50, 32'h10, 32'hA000, 32'hB000, 32'h60);
        put_desc(32'h60, 32'h18, 32'hC000, 32'hD000, 32'h50);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(OFF_CTRL, v);  check("R1 ctrl", v, 32'h0);
        rd(OFF_STAT, v);  check("R1 status", v, 32'h0);
        rd(OFF_CUR, v);   check("R1 current", v, 32'h0);
        rd(OFF_COUNT, v); check("R1 count", v, 32'h0);
        check("R1 run", 32'(xfer_run), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 R5 linear chain of two
        wr(OFF_MASK, 32'h1);
        expect_job(32'h1000, 32'h2000, 32'h40);
        expect_job(32'h3000, 32'h4000, 32'h80);
        done_limit = 2;
        wr(OFF_NEXT, 32'h10);
        wr(OFF_CTRL, 32'h3000);
        repeat (60) @(negedge clk);
        check("R5 jobs started", 32'(start_cnt), 32'd2);
        rd(OFF_CTRL, v);  check("R9 R5 chain ended idle", v, 32'h1000);
        rd(OFF_CUR, v);   check("R2 current", v, 32'h20);
        rd(OFF_SRC, v);   check("R2 source word", v, 32'h3000);
        rd(OFF_DST, v);   check("R2 dest word", v, 32'h4000);
        rd(OFF_STAT, v);  check("R5 status set", v, 32'h1);
        check("R10 irq raised", 32'(irq), 32'h1);

        // R10 sticky flag
        wr(OFF_STAT, 32'h1);
        rd(OFF_STAT, v);  check("R10 write one keeps", v, 32'h1);
        wr(OFF_STAT, 32'h0);
        rd(OFF_STAT, v);  check("R10 write zero clears", v, 32'h0);
        check("R10 irq low", 32'(irq), 32'h0);

        // R3 fetch while disabled, mask off
        wr(OFF_MASK, 32'h0);
        wr(OFF_NEXT, 32'h20);
        wr(OFF_CTRL, 32'h2000);
        repeat (10) @(negedge clk);
        check("R3 no run while disabled", 32'(xfer_run), 32'h0);
        rd(OFF_CTRL, v);  check("R9 active loaded", v, 32'h4000);
        rd(OFF_COUNT, v); check("R2 count word", v, 32'h80);
        expect_job(32'h3000, 32'h4000, 32'h80);
        done_limit = 3;
        wr(OFF_CTRL, 32'h1000);
        repeat (20) @(negedge clk);
        check("R3 started on enable", 32'(start_cnt), 32'd3);
        rd(OFF_STAT, v);  check("R5 status", v, 32'h1);
        check("R10 masked irq", 32'(irq), 32'h0);
        wr(OFF_STAT, 32'h0);

        // R2 alignment, R4 clamp
        expect_job(32'h5000, 32'h6000, 32'h10000);
        done_limit = 4;
        wr(OFF_NEXT, 32'h37);
        wr(OFF_CTRL, 32'h3000);
        repeat (20) @(negedge clk);
        rd(OFF_CUR, v);   check("R2 aligned pointer", v, 32'h30);
        rd(OFF_COUNT, v); check("R4 clamped count", v, 32'h10000);
        check("R4 job count", 32'(start_cnt), 32'd4);

        // R7 pause and R11 ignored fetch
        expect_job(32'h7000, 32'h8000, 32'h20);
        wr(OFF_NEXT, 32'h40);
        wr(OFF_CTRL, 32'h3000);
        repeat (8) @(negedge clk);
        check("R7 running", 32'(xfer_run), 32'h1);
        wr(OFF_CTRL, 32'h0);
        check("R7 paused run low", 32'(xfer_run), 32'h0);
        rd(OFF_CTRL, v);  check("R7 still active", v, 32'h4000);
        wr(OFF_CTRL, 32'h2000);
        repeat (3) @(negedge clk);
        rd(OFF_CUR, v);   check("R11 current kept", v, 32'h40);
        check("R11 job kept", xfer_src, 32'h7000);
        done_limit = 5;
        wr(OFF_CTRL, 32'h1000);
        repeat (15) @(negedge clk);
        check("R7 no new job on resume", 32'(start_cnt), 32'd5);
        check("R7 resumed job finished", 32'(done_cnt), 32'd5);
        rd(OFF_CTRL, v);  check("R7 idle after", v, 32'h1000);

        // R6 ring, then R8 abort with fetch
        for (int k = 0; k < 3; k++) begin
            expect_job(32'hA000, 32'hB000, 32'h10);
            expect_job(32'hC000, 32'hD000, 32'h18);
        end
        done_limit = 10;
        wr(OFF_NEXT, 32'h50);
        wr(OFF_CTRL, 32'h3000);
        repeat (80) @(negedge clk);
        check("R6 ring jobs", 32'(start_cnt), 32'd11);
        check("R6 still looping", 32'(xfer_run), 32'h1);
        rd(OFF_CUR, v);   check("R6 ring position", v, 32'h60);
        wr(OFF_CTRL, 32'h0010_3000);
        seen = 1'b0;
        check("R8 run dropped", 32'(xfer_run), 32'h0);
        rd(OFF_CTRL, v);  check("R8 idle and disabled", v, 32'h0);
        repeat (3) @(negedge clk);
        check("R8 no fetch", 32'(mem_req), 32'h0);
        check("R6 scoreboard drained", 32'(exp_q.size()), 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule